// File: doc/BRIEF.md
# Tone-Locked PWM Buzzer Driver

This block drives one buzzer pin. When driving is enabled, the pin carries a pulse-width-modulated square wave whose period is locked to an external first tone: each tone period is split into 128 slots, counted from a slot strobe that arrives 128 times per period. A 6-bit duty code sets how many of those slots form the active pulse, so the pulse covers at most 63/128 of the period. A polarity input decides whether the active pulse is a high or a low phase. A second square-wave tone gates the pulse on and off, which gives amplitude modulation at the second tone's rate.

When driving is disabled, the pin holds a static level equal to the inverse of the polarity input, and this takes effect in the same cycle. Duty, polarity and enabling are taken into a shadow copy only at the start of a first-tone period, so a pulse is never cut or stretched by a change in the middle of a period. A three-state machine tracks this: STATIC (not driving), ARMED (enable seen, waiting for a period start) and RUN (driving with the shadow settings). Transitions: STATIC to ARMED when enable rises between period starts; STATIC to RUN when enable is high at a period start; ARMED to RUN at the next period start; ARMED or RUN to STATIC as soon as enable is low; RUN to RUN at each period start, reloading the shadow copy.

Top module: `buzzer_pwm_drv`

## Requirements
- R1: While `rst_n` is low, `buzz_out` is 1 whatever the other inputs; after reset with `drv_en`=0 and `drv_pol`=0 it stays 1.
- R2: With `drv_en`=0, `buzz_out` equals the inverse of `drv_pol` in the same cycle, independent of duty, strobes and tones, including when enable drops in the middle of a period.
- R3: The slot count returns to 0 in the cycle after a rising edge of `tone1_sq` is seen, advances by one for each cycle with `slot_tick`=1, holds when `slot_tick`=0, and saturates at 127 instead of wrapping.
- R4: In RUN with `tone2_sq`=1, the pin is at its active level exactly while the slot count is below the shadow duty code, so the pulse lasts duty/128 of a period of 128 strobes.
- R5: Shadow polarity 1 makes the active level 1 and the idle level 0; shadow polarity 0 makes the active level 0 and the idle level 1.
- R6: In RUN, `tone2_sq`=0 forces the pin to the idle level in the same cycle.
- R7: In RUN, a shadow duty code of 0 gives a constant idle level with no pulse.
- R8: Duty and polarity are copied into the shadow, and RUN is entered, only at a `tone1_sq` rising edge with `drv_en`=1, taking effect from the next cycle; before the first such edge after enabling, the pin keeps the static level (inverse of live `drv_pol`), and mid-period changes of duty or polarity do not alter the current period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en | input | 1 | Enable PWM driving (1) or static level (0) |
| drv_pol | input | 1 | Polarity: 1 = duty measured on high phase, 0 = on low phase |
| duty_code | input | 6 | Active slots per 128-slot period |
| slot_tick | input | 1 | Slot strobe, 128 per first-tone period |
| tone1_sq | input | 1 | First tone square wave; rising edge starts a period |
| tone2_sq | input | 1 | Second tone square wave; low gates the pulse off |
| buzz_out | output | 1 | Buzzer pin |

## Verification
Two pairs of functions can meet in one cycle: second-tone gating landing on an active slot, and a mid-period enable drop or settings change landing while a pulse is in progress. The bench provokes the first by toggling the second tone every few cycles across a full-width pulse and expects idle in every gated slot; it provokes the second by dropping enable or rewriting duty and polarity inside the active window and expects the static level at once for the drop, but the unchanged old pulse for the rewrite until the next period start. Expected levels come from a slot count the bench keeps from its own strobes, over every duty code in both polarities.

// File: rtl/buzz_pkg.sv
package buzz_pkg;

    typedef enum logic [1:0] {
        ST_STATIC = 2'd0,
        ST_ARMED  = 2'd1,
        ST_RUN    = 2'd2
    } drv_state_t;

endpackage

// File: rtl/buzz_edge_det.sv
module buzz_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise_o
);

    logic sig_q;

    // Reset to 1 so a tone that is already high at reset release is not a start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sig_q <= 1'b1;
        else        sig_q <= sig_in;
    end

    assign rise_o = sig_in & ~sig_q;

endmodule

// File: rtl/buzz_slot_cnt.sv
module buzz_slot_cnt #(
    parameter int SLOT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              adv,
    output logic [SLOT_W-1:0] slot
);

    localparam logic [SLOT_W-1:0] SLOT_MAX = {SLOT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     slot <= '0;
        else if (restart)               slot <= '0;
        else if (adv && slot != SLOT_MAX) slot <= slot + 1'b1;
    end

    assert_restart_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> slot == '0);

    assert_saturate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && adv && slot == SLOT_MAX) |=> slot == SLOT_MAX);

    assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !adv) |=> $stable(slot));

endmodule

// File: rtl/buzz_ctrl_fsm.sv
module buzz_ctrl_fsm
    import buzz_pkg::*;
#(
    parameter int DUTY_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_req,
    input  logic              pol_req,
    input  logic [DUTY_W-1:0] duty_req,
    input  logic              boundary,
    output drv_state_t        state,
    output logic              pol_sh,
    output logic [DUTY_W-1:0] duty_sh
);

    drv_state_t nxt;
    logic       load_cfg;

    assign load_cfg = en_req & boundary;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_STATIC;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_STATIC: begin
                if (en_req) nxt = boundary ? ST_RUN : ST_ARMED;
            end
            ST_ARMED: begin
                if (!en_req)      nxt = ST_STATIC;
                else if (boundary) nxt = ST_RUN;
            end
            ST_RUN: begin
                if (!en_req) nxt = ST_STATIC;
            end
            default: nxt = ST_STATIC;
        endcase
    end

    // Shadow settings, loaded only at a period start while enabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_sh  <= 1'b0;
            duty_sh <= '0;
        end else if (load_cfg) begin
            pol_sh  <= pol_req;
            duty_sh <= duty_req;
        end
    end

    assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(en_req && boundary) |=> ($stable(duty_sh) && $stable(pol_sh)));

    assert_run_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN && !(en_req && boundary)) |=> state != ST_RUN);

    assert_leave_on_disable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_req |=> state == ST_STATIC);

endmodule

// File: rtl/buzz_out_stage.sv
module buzz_out_stage
    import buzz_pkg::*;
#(
    parameter int DUTY_W = 6,
    parameter int SLOT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_req,
    input  logic              pol_req,
    input  drv_state_t        state,
    input  logic              pol_sh,
    input  logic [DUTY_W-1:0] duty_sh,
    input  logic [SLOT_W-1:0] slot,
    input  logic              am_gate,
    output logic              pin
);

    logic in_window;
    logic driving;

    assign in_window = slot < SLOT_W'(duty_sh);
    assign driving   = en_req && (state == ST_RUN);

    // Output process
    always_comb begin
        if (!rst_n)        pin = 1'b1;
        else if (!driving) pin = ~pol_req;
        else               pin = (in_window && am_gate) ? pol_sh : ~pol_sh;
    end

    assert_static_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_req |-> pin == ~pol_req);

    assert_am_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && en_req && !am_gate) |-> pin == ~pol_sh);

    assert_zero_duty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && en_req && duty_sh == '0) |-> pin == ~pol_sh);

    assert_outside_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && en_req && SLOT_W'(duty_sh) <= slot) |-> pin == ~pol_sh);

endmodule

// File: rtl/buzzer_pwm_drv.sv
module buzzer_pwm_drv
    import buzz_pkg::*;
#(
    parameter int DUTY_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              drv_en,
    input  logic              drv_pol,
    input  logic [DUTY_W-1:0] duty_code,
    input  logic              slot_tick,
    input  logic              tone1_sq,
    input  logic              tone2_sq,
    output logic              buzz_out
);

    localparam int SLOT_W = DUTY_W + 1;

    logic              period_start;
    logic [SLOT_W-1:0] slot;
    drv_state_t        state;
    logic              pol_sh;
    logic [DUTY_W-1:0] duty_sh;

    buzz_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_in (tone1_sq),
        .rise_o (period_start)
    );

    buzz_slot_cnt #(.SLOT_W(SLOT_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (period_start),
        .adv     (slot_tick),
        .slot    (slot)
    );

    buzz_ctrl_fsm #(.DUTY_W(DUTY_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_req   (drv_en),
        .pol_req  (drv_pol),
        .duty_req (duty_code),
        .boundary (period_start),
        .state    (state),
        .pol_sh   (pol_sh),
        .duty_sh  (duty_sh)
    );

    buzz_out_stage #(.DUTY_W(DUTY_W), .SLOT_W(SLOT_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_req  (drv_en),
        .pol_req (drv_pol),
        .state   (state),
        .pol_sh  (pol_sh),
        .duty_sh (duty_sh),
        .slot    (slot),
        .am_gate (tone2_sq),
        .pin     (buzz_out)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_high_R1: assert (buzz_out == 1'b1);
        end
    end

endmodule

// File: tb/tb_buzzer_pwm_drv.sv
module tb_buzzer_pwm_drv;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       drv_en;
    logic       drv_pol;
    logic [5:0] duty_code;
    logic       slot_tick;
    logic       tone1_sq;
    logic       tone2_sq;
    logic       buzz_out;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    always #10 clk = ~clk;   // 50 MHz

    buzzer_pwm_drv dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .drv_en    (drv_en),
        .drv_pol   (drv_pol),
        .duty_code (duty_code),
        .slot_tick (slot_tick),
        .tone1_sq  (tone1_sq),
        .tone2_sq  (tone2_sq),
        .buzz_out  (buzz_out)
    );

    task automatic chk(input logic exp, input string req);
        checks++;
        if (buzz_out !== exp) begin
            fails++;
            $display("FAIL %s: buzz_out=%b expected=%b at %0t", req, buzz_out, exp, $time);
        end
    endtask

    // One cycle with no period start and no strobe; inputs set at the falling edge,
    // sampled 5 ns later, before the next rising edge.
    task automatic quiet_cyc(input logic exp, input string req);
        @(negedge clk);
        tone1_sq  = 1'b0;
        slot_tick = 1'b0;
        #5;
        chk(exp, req);
    endtask

    // One first-tone period: a start cycle, then ncyc cycles checked against a
    // slot count kept from the bench's own strobes.
    task automatic period(input int d_exp, input bit p_exp, input int gap,
                          input int am_half, input int ncyc,
                          input int mid_at, input int mid_duty, input bit mid_pol,
                          input int dis_at, input string req);
        int slot = 0;
        bit run  = 1'b1;
        logic exp;
        @(negedge clk);
        tone1_sq  = 1'b1;
        slot_tick = 1'b0;
        tone2_sq  = 1'b1;
        for (int k = 1; k <= ncyc; k++) begin
            @(negedge clk);
            tone1_sq  = (k < 64);
            slot_tick = (((k - 1) % gap) == 0);
            tone2_sq  = (am_half == 0) ? 1'b1 : (((k / am_half) % 2) == 0);
            if (k == mid_at) begin
                duty_code = mid_duty[5:0];
                drv_pol   = mid_pol;
            end
            if (k == dis_at) begin
                drv_en = 1'b0;
                run    = 1'b0;
            end
            #5;
            if (run) exp = ((slot < d_exp) && tone2_sq) ? p_exp : !p_exp;
            else     exp = !drv_pol;
            chk(exp, req);
            if (slot_tick && slot < 127) slot++;
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1..all: run not finished, expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        drv_en    = 1'b1;
        drv_pol   = 1'b1;
        duty_code = 6'd20;
        slot_tick = 1'b1;
        tone1_sq  = 1'b0;
        tone2_sq  = 1'b1;

        // R1: output high during reset regardless of inputs
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            tone1_sq = i[0];
            #5;
            chk(1'b1, "R1 in reset");
        end
        @(negedge clk);
        drv_en   = 1'b0;
        drv_pol  = 1'b0;
        tone1_sq = 1'b0;
        rst_n    = 1'b1;
        #5;
        chk(1'b1, "R1 after reset");
        quiet_cyc(1'b1, "R1 after reset");

        // R2: static level follows inverse of polarity at once
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            drv_pol   = i[0];
            tone2_sq  = i[1];
            slot_tick = i[2];
            tone1_sq  = i[1];
            duty_code = 6'(i * 9);
            #5;
            chk(!drv_pol, "R2 static");
        end
        period(0, 0, 1, 0, 70, -1, 0, 0, 1, "R2 static period");

        // R8: enable waits for the next period start
        drv_pol   = 1'b1;
        duty_code = 6'd10;
        @(negedge clk);
        drv_en = 1'b1;
        #5;
        chk(1'b0, "R8 armed");
        quiet_cyc(1'b0, "R8 armed");
        quiet_cyc(1'b0, "R8 armed");
        period(10, 1, 1, 0, 130, -1, 0, 0, -1, "R8 first period");

        // R4 R5 R7: every duty code in both polarities
        for (int p = 0; p < 2; p++) begin
            for (int d = 0; d < 64; d++) begin
                duty_code = d[5:0];
                drv_pol   = p[0];
                period(d, p[0], 1, 0, 130, -1, 0, 0, -1, "R4 R5 R7 sweep");
            end
        end

        // R6: second tone gating over a full-width pulse
        duty_code = 6'd63;
        drv_pol   = 1'b1;
        period(63, 1, 1, 4, 130, -1, 0, 0, -1, "R6 gate pol1");
        drv_pol   = 1'b0;
        period(63, 0, 1, 3, 130, -1, 0, 0, -1, "R6 gate pol0");

        // R3: strobe every other cycle, and saturation without wrap
        duty_code = 6'd30;
        drv_pol   = 1'b1;
        period(30, 1, 2, 0, 260, -1, 0, 0, -1, "R3 sparse strobes");
        duty_code = 6'd63;
        period(63, 1, 1, 0, 300, -1, 0, 0, -1, "R3 saturation");

        // R8: mid-period rewrite is deferred
        period(63, 1, 1, 0, 130, 40, 5, 0, -1, "R8 deferred rewrite");
        period(5, 0, 1, 0, 130, -1, 0, 0, -1, "R8 rewrite applied");

        // R2: enable drop inside the active window
        duty_code = 6'd40;
        drv_pol   = 1'b1;
        period(40, 1, 1, 0, 130, -1, 0, 0, -1, "R2 pre-drop");
        period(40, 1, 1, 0, 130, -1, 0, 0, 20, "R2 drop mid pulse");

        // R8: re-enable mid-period stays static, following live polarity
        @(negedge clk);
        drv_en = 1'b1;
        #5;
        chk(1'b0, "R8 re-armed");
        @(negedge clk);
        drv_pol = 1'b0;
        #5;
        chk(1'b1, "R8 re-armed pol change");
        quiet_cyc(1'b1, "R8 re-armed");
        period(40, 0, 1, 0, 130, -1, 0, 0, -1, "R8 re-enabled period");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule